// File: doc/BRIEF.md
# Chip-Select Generator With Wait States

This block sits between a host bus and a set of simple asynchronous memory or I/O devices. Each bank has a base register and an option register. When the host presents an address with a start pulse, every valid bank compares the upper address bits with its base address, but only at the bit positions its option mask enables. The lowest-numbered bank that matches is chosen. The block then drives that bank's chip-select together with a shared output-enable (reads) or write-enable (writes), holds them for a programmed number of wait states, and returns an internal acknowledge.

Each bank's option register sets three things:
- a cycle length, which can be doubled by a relaxed-timing bit;
- early negation of chip-select and write-enable;
- an idle turnaround clock after reads, inserted when the next access targets another bank.

An external acknowledge that arrives while the strobes are active ends the cycle at once, and no internal acknowledge is produced. An access that hits no bank ends in an error pulse after a fixed timeout. A write to a write-protected bank ends in an error pulse on the next clock, and no strobes are driven.

Banks are programmed through one register-write port that selects a bank and either its base or its option word. Strobes, acknowledge and error are registered outputs. All are active high.

Top module: `csg_chip_select`

## Requirements
- R1: Base word layout: bits [31:15] are the base tag, bit 0 is valid and bit 1 is write-protect. Option word layout: bits [31:15] are the compare mask, bits [3:0] are the cycle length, bit 4 enables early negation, bit 5 is relaxed timing and bit 6 is read hold. A bank matches only when its valid bit is 1 and address bits [31:15] equal the base tag at every position where the mask bit is 1.
- R2: When more than one bank matches, only the lowest-numbered matching bank receives a chip-select.
- R3: A write to a matching bank whose write-protect bit is 1 drives no chip-select, output-enable or write-enable. It raises `err` for one cycle, one clock after the clock edge that takes the start. A read from such a bank proceeds normally.
- R4: Let the edge that takes `start` be edge 0, and let W be the number of wait states. Strobes are active from edge 0 and drop after edge W+1, and `ack` is high for exactly one cycle after edge W+1. W equals the cycle-length field.
- R5: With relaxed timing set, W is twice the cycle-length field.
- R6: With early negation set and W at least 1, chip-select and write-enable drop one clock early, so they are active for W cycles. Output-enable keeps its full W+1 cycles. With W = 0 there is no change.
- R7: An external acknowledge sampled on an edge while the strobes are active ends the cycle on that edge, including the edge on which the internal count would have ended it. No internal `ack` is produced for that access.
- R8: After a read from a bank with read hold set, the next access that matches a different bank starts its strobes one clock later, and its `ack` also comes one clock later. The next access to the same bank, or an access that follows a write, has no delay.
- R9: An access that matches no bank drives no strobes. It raises `err` for one cycle, TIMEOUT clocks after the edge that takes the start.
- R10: After reset all strobes, `ack`, `err` and `busy` are low, and every bank is invalid, so the first access before configuration times out.
- R11: Output-enable is asserted only for reads and write-enable only for writes. `busy` is high from the edge that takes the start until the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_bank | input | BANK_W | Bank selected for the register write |
| cfg_opt | input | 1 | 1 writes the option word, 0 writes the base word |
| cfg_wdata | input | ADDR_W | Register write data |
| start | input | 1 | Host access start, one cycle, only while `busy` is low |
| addr | input | ADDR_W | Host address, sampled with `start` |
| rd | input | 1 | 1 = read, 0 = write, sampled with `start` |
| ext_ack | input | 1 | External transfer acknowledge |
| cs | output | NUM_BANKS | Per-bank chip-selects |
| oe | output | 1 | Output-enable strobe |
| we | output | 1 | Write-enable strobe |
| ack | output | 1 | Internal transfer acknowledge, one cycle |
| err | output | 1 | Error pulse for a missed or write-protected access |
| busy | output | 1 | Access in progress |

## Verification
The assertions rely on two properties of the host's behaviour:
- the host raises `start` only while `busy` is low, and for exactly one cycle;
- the host does not rewrite the registers of a bank during that bank's access.

The bench keeps to both rules. Each access runs through a fixed 40-cycle observation window, which is longer than the longest possible access, and the bench programs registers only between windows. The external acknowledge is pulsed only at chosen points inside a window.

// File: rtl/csg_pkg.sv
package csg_pkg;

  localparam int SCY_W  = 4;
  localparam int WAIT_W = SCY_W + 1;

  // control bit positions in the low part of the configuration words
  localparam int B_VALID = 0;
  localparam int B_WP    = 1;
  localparam int O_EARLY = 4;
  localparam int O_RELAX = 5;
  localparam int O_HOLD  = 6;

  typedef struct packed {
    logic             wp;
    logic             rdhold;
    logic             relax;
    logic             early;
    logic [SCY_W-1:0] scy;
  } bank_attr_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_ACT  = 2'd2,
    ST_ERR  = 2'd3
  } seq_state_t;

endpackage

// File: rtl/csg_bank_regs.sv
module csg_bank_regs
  import csg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 32,
  parameter int TAG_W     = 17,
  parameter int BANK_W    = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_we,
  input  logic [BANK_W-1:0]              cfg_bank,
  input  logic                           cfg_opt,
  input  logic [ADDR_W-1:0]              cfg_wdata,
  input  logic [ADDR_W-1:0]              addr,
  output logic [NUM_BANKS-1:0]           hit_vec,
  output bank_attr_t [NUM_BANKS-1:0]     attr_o
);

  localparam int TAG_LSB = ADDR_W - TAG_W;

  logic [TAG_W-1:0] addr_tag;
  logic             cfg_unused;

  assign addr_tag   = addr[ADDR_W-1:TAG_LSB];
  assign cfg_unused = ^{cfg_wdata, addr};

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [TAG_W-1:0] tag_q;
    logic [TAG_W-1:0] mask_q;
    logic             valid_q;
    logic             wp_q;
    logic [SCY_W-1:0] scy_q;
    logic             early_q;
    logic             relax_q;
    logic             hold_q;
    logic             sel;

    assign sel = cfg_we && (cfg_bank == BANK_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        tag_q   <= '0;
        valid_q <= 1'b0;
        wp_q    <= 1'b0;
        mask_q  <= '0;
        scy_q   <= '0;
        early_q <= 1'b0;
        relax_q <= 1'b0;
        hold_q  <= 1'b0;
      end else if (sel) begin
        if (cfg_opt) begin
          mask_q  <= cfg_wdata[ADDR_W-1:TAG_LSB];
          scy_q   <= cfg_wdata[SCY_W-1:0];
          early_q <= cfg_wdata[O_EARLY];
          relax_q <= cfg_wdata[O_RELAX];
          hold_q  <= cfg_wdata[O_HOLD];
        end else begin
          tag_q   <= cfg_wdata[ADDR_W-1:TAG_LSB];
          valid_q <= cfg_wdata[B_VALID];
          wp_q    <= cfg_wdata[B_WP];
        end
      end
    end

    assign hit_vec[g] = valid_q && (((addr_tag ^ tag_q) & mask_q) == '0);

    always_comb begin
      attr_o[g].wp     = wp_q;
      attr_o[g].rdhold = hold_q;
      attr_o[g].relax  = relax_q;
      attr_o[g].early  = early_q;
      attr_o[g].scy    = scy_q;
    end
  end

endmodule

// File: rtl/csg_prio.sv
module csg_prio #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic [NUM_BANKS-1:0] hit_vec,
  output logic                 any_hit,
  output logic [BANK_W-1:0]    hit_idx
);

  always_comb begin
    hit_idx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = BANK_W'(i);
    end
  end

  assign any_hit = |hit_vec;

endmodule

// File: rtl/csg_seq.sv
module csg_seq
  import csg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int TIMEOUT   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 rd,
  input  logic                 hit,
  input  logic [BANK_W-1:0]    hit_idx,
  input  bank_attr_t           attr_i,
  input  logic                 ext_ack,
  output logic [NUM_BANKS-1:0] cs,
  output logic                 oe,
  output logic                 we,
  output logic                 ack,
  output logic                 err,
  output logic                 busy
);

  localparam int TO_W = $clog2(TIMEOUT + 1);

  seq_state_t           state_q;
  logic [WAIT_W-1:0]    wcnt_q;
  logic [TO_W-1:0]      tcnt_q;
  logic [BANK_W-1:0]    bank_q;
  logic                 rd_q;
  logic                 early_q;
  logic                 hold_cur_q;
  logic                 hold_pend_q;
  logic [BANK_W-1:0]    hold_bank_q;
  logic [NUM_BANKS-1:0] cs_q;
  logic                 oe_q;
  logic                 we_q;
  logic                 ack_q;
  logic                 err_q;
  logic [WAIT_W-1:0]    waits;

  assign waits = attr_i.relax ? {attr_i.scy, 1'b0} : {1'b0, attr_i.scy};

  function automatic logic [NUM_BANKS-1:0] onehot(input logic [BANK_W-1:0] idx);
    logic [NUM_BANKS-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (idx == BANK_W'(i)) v[i] = 1'b1;
    end
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      wcnt_q      <= '0;
      tcnt_q      <= '0;
      bank_q      <= '0;
      rd_q        <= 1'b0;
      early_q     <= 1'b0;
      hold_cur_q  <= 1'b0;
      hold_pend_q <= 1'b0;
      hold_bank_q <= '0;
      cs_q        <= '0;
      oe_q        <= 1'b0;
      we_q        <= 1'b0;
      ack_q       <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            hold_pend_q <= 1'b0;
            if (!hit) begin
              state_q <= ST_ERR;
              tcnt_q  <= TO_W'(TIMEOUT - 1);
            end else if (!rd && attr_i.wp) begin
              state_q <= ST_ERR;
              tcnt_q  <= '0;
            end else begin
              bank_q     <= hit_idx;
              rd_q       <= rd;
              early_q    <= attr_i.early;
              hold_cur_q <= rd && attr_i.rdhold;
              wcnt_q     <= waits;
              if (hold_pend_q && (hold_bank_q != hit_idx)) begin
                state_q <= ST_GAP;
              end else begin
                state_q <= ST_ACT;
                cs_q    <= onehot(hit_idx);
                oe_q    <= rd;
                we_q    <= !rd;
              end
            end
          end
        end
        ST_GAP: begin
          state_q <= ST_ACT;
          cs_q    <= onehot(bank_q);
          oe_q    <= rd_q;
          we_q    <= !rd_q;
        end
        ST_ACT: begin
          if (ext_ack || (wcnt_q == '0)) begin
            state_q <= ST_IDLE;
            cs_q    <= '0;
            oe_q    <= 1'b0;
            we_q    <= 1'b0;
            ack_q   <= !ext_ack;
            if (hold_cur_q) begin
              hold_pend_q <= 1'b1;
              hold_bank_q <= bank_q;
            end
          end else begin
            wcnt_q <= wcnt_q - 1'b1;
            if (early_q && (wcnt_q == WAIT_W'(1))) begin
              cs_q <= '0;
              we_q <= 1'b0;
            end
          end
        end
        ST_ERR: begin
          if (tcnt_q == '0) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
          end else begin
            tcnt_q <= tcnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs   = cs_q;
  assign oe   = oe_q;
  assign we   = we_q;
  assign ack  = ack_q;
  assign err  = err_q;
  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/csg_chip_select.sv
module csg_chip_select
  import csg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 32,
  parameter int TAG_W     = 17,
  parameter int TIMEOUT   = 16,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [BANK_W-1:0]    cfg_bank,
  input  logic                 cfg_opt,
  input  logic [ADDR_W-1:0]    cfg_wdata,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd,
  input  logic                 ext_ack,
  output logic [NUM_BANKS-1:0] cs,
  output logic                 oe,
  output logic                 we,
  output logic                 ack,
  output logic                 err,
  output logic                 busy
);

  logic [NUM_BANKS-1:0]       hit_vec;
  bank_attr_t [NUM_BANKS-1:0] attr_all;
  bank_attr_t                 sel_attr;
  logic                       any_hit;
  logic [BANK_W-1:0]          hit_idx;

  csg_bank_regs #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .BANK_W(BANK_W)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_opt(cfg_opt), .cfg_wdata(cfg_wdata), .addr(addr),
    .hit_vec(hit_vec), .attr_o(attr_all)
  );

  csg_prio #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_prio (
    .hit_vec(hit_vec), .any_hit(any_hit), .hit_idx(hit_idx)
  );

  assign sel_attr = attr_all[hit_idx];

  csg_seq #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .TIMEOUT(TIMEOUT)) u_seq (
    .clk(clk), .rst(rst), .start(start), .rd(rd), .hit(any_hit),
    .hit_idx(hit_idx), .attr_i(sel_attr), .ext_ack(ext_ack),
    .cs(cs), .oe(oe), .we(we), .ack(ack), .err(err), .busy(busy)
  );

endmodule

// File: rtl/csg_checker.sv
module csg_checker #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ext_ack,
  input logic [NUM_BANKS-1:0] cs,
  input logic                 oe,
  input logic                 we,
  input logic                 ack,
  input logic                 err,
  input logic                 busy
);

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs)); // R2

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(oe && we)); // R11

  AST_WE_WITH_CS: assert property (@(posedge clk) disable iff (rst)
    we |-> (cs != '0)); // R6

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R4

  AST_ACK_STROBES_OFF: assert property (@(posedge clk) disable iff (rst)
    ack |-> (cs == '0 && !oe && !we && !err)); // R4

  AST_EXT_SUPPRESS_ACK: assert property (@(posedge clk) disable iff (rst)
    (ext_ack && (oe || we || (cs != '0))) |=> !ack); // R7

  AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    err |-> (cs == '0 && !oe && !we)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs == '0 && !oe && !we)); // R11

endmodule

bind csg_chip_select csg_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst(rst), .ext_ack(ext_ack), .cs(cs), .oe(oe), .we(we),
  .ack(ack), .err(err), .busy(busy)
);

// File: tb/tb_csg_chip_select.sv
module tb_csg_chip_select;

  localparam int NB   = 4;
  localparam int AW   = 32;
  localparam int TO   = 16;
  localparam int WIN  = 40;
  localparam int BW   = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [BW-1:0] cfg_bank = '0;
  logic          cfg_opt = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rd = 1'b0;
  logic          ext_ack = 1'b0;
  logic [NB-1:0] cs;
  logic          oe, we, ack, err, busy;

  int nchk = 0;
  int nerr = 0;

  int cs_cnt [NB];
  int cs_first [NB];
  int oe_cnt, oe_first, we_cnt, ack_at, ack_cnt, err_at, err_cnt;
  logic busy_end;

  always #2.5 clk = ~clk;

  csg_chip_select #(.NUM_BANKS(NB), .ADDR_W(AW), .TAG_W(17), .TIMEOUT(TO)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_opt(cfg_opt), .cfg_wdata(cfg_wdata), .start(start), .addr(addr),
    .rd(rd), .ext_ack(ext_ack), .cs(cs), .oe(oe), .we(we), .ack(ack),
    .err(err), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int b, input logic o, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = BW'(b); cfg_opt = o; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [AW-1:0] opt_word(input logic [AW-1:0] mask, input int scy,
                                             input bit early, input bit relax, input bit hold);
    return (mask & 32'hFFFF_8000) | (32'(hold) << 6) | (32'(relax) << 5)
           | (32'(early) << 4) | 32'(scy & 15);
  endfunction

  task automatic run_txn(input logic [AW-1:0] a, input logic r, input int ext_at);
    @(negedge clk);
    chk("R11 idle before start", int'(busy), 0);
    addr = a; rd = r; start = 1'b1;
    for (int b = 0; b < NB; b++) begin cs_cnt[b] = 0; cs_first[b] = 0; end
    oe_cnt = 0; oe_first = 0; we_cnt = 0; ack_at = 0; ack_cnt = 0; err_at = 0; err_cnt = 0;
    for (int i = 1; i <= WIN; i++) begin
      @(negedge clk);
      start = 1'b0;
      for (int b = 0; b < NB; b++) begin
        if (cs[b]) begin cs_cnt[b]++; if (cs_first[b] == 0) cs_first[b] = i; end
      end
      if (oe) begin oe_cnt++; if (oe_first == 0) oe_first = i; end
      if (we) we_cnt++;
      if (ack) begin ack_cnt++; if (ack_at == 0) ack_at = i; end
      if (err) begin err_cnt++; if (err_at == 0) err_at = i; end
      ext_ack = (i == ext_at);
    end
    ext_ack = 1'b0;
    busy_end = busy;
  endtask

  task automatic expect_access(input string req, input int bank, input bit r,
                               input int w, input bit early, input int gap);
    int cs_len;
    int others;
    cs_len = (early && w >= 1) ? w : w + 1;
    others = 0;
    for (int b = 0; b < NB; b++) if (b != bank) others += cs_cnt[b];
    chk({req, " cs length"}, cs_cnt[bank], cs_len);
    chk({req, " cs first cycle"}, cs_first[bank], 1 + gap);
    chk({req, " other cs"}, others, 0);
    chk({req, " R11 oe length"}, oe_cnt, r ? w + 1 : 0);
    chk({req, " R11 we length"}, we_cnt, r ? 0 : cs_len);
    chk({req, " ack cycle"}, ack_at, w + 2 + gap);
    chk({req, " ack count"}, ack_cnt, 1);
    chk({req, " no err"}, err_cnt, 0);
    chk({req, " busy released"}, int'(busy_end), 0);
  endtask

  task automatic expect_err(input string req, input int at);
    int tot;
    tot = 0;
    for (int b = 0; b < NB; b++) tot += cs_cnt[b];
    chk({req, " err cycle"}, err_at, at);
    chk({req, " err count"}, err_cnt, 1);
    chk({req, " no cs"}, tot, 0);
    chk({req, " no oe/we"}, oe_cnt + we_cnt, 0);
    chk({req, " no ack"}, ack_cnt, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk("R10 cs after reset", int'(cs), 0);
    chk("R10 oe/we after reset", int'(oe) + int'(we), 0);
    chk("R10 ack/err after reset", int'(ack) + int'(err), 0);
    chk("R10 busy after reset", int'(busy), 0);
    run_txn(32'h8000_0010, 1'b1, 0);
    expect_err("R10 unconfigured bank times out", TO + 1);

    cfg_write(0, 1'b0, 32'h8000_0001);
    cfg_write(0, 1'b1, opt_word(32'hFFFF_8000, 1, 0, 0, 0));
    cfg_write(1, 1'b0, 32'h4000_0001);
    cfg_write(1, 1'b1, opt_word(32'hFF00_0000, 0, 0, 0, 0));
    cfg_write(2, 1'b0, 32'h4000_0001);
    cfg_write(2, 1'b1, opt_word(32'hF000_0000, 3, 0, 0, 0));
    cfg_write(3, 1'b0, 32'hC000_0000);
    cfg_write(3, 1'b1, opt_word(32'hFFFF_8000, 0, 0, 0, 0));

    // R1: masked matching and valid bit
    run_txn(32'h8000_7FFC, 1'b1, 0);
    expect_access("R1 inside 32KB window", 0, 1, 1, 0, 0);
    run_txn(32'h8000_8000, 1'b1, 0);
    expect_err("R1 just past window (R9)", TO + 1);
    run_txn(32'h7FFF_FFFC, 1'b0, 0);
    expect_err("R1 just below window (R9)", TO + 1);
    run_txn(32'hC000_0010, 1'b1, 0);
    expect_err("R1 invalid bank ignored", TO + 1);
    cfg_write(3, 1'b0, 32'hC000_0001);
    run_txn(32'hC000_0010, 1'b0, 0);
    expect_access("R1 bank valid after set", 3, 0, 0, 0, 0);

    // R2: priority on overlap
    run_txn(32'h40FF_8000, 1'b1, 0);
    expect_access("R2 overlap lowest bank", 1, 1, 0, 0, 0);
    run_txn(32'h4100_0000, 1'b1, 0);
    expect_access("R2 only higher bank", 2, 1, 3, 0, 0);

    // R3: write protect
    cfg_write(2, 1'b0, 32'h4000_0003);
    run_txn(32'h4100_0000, 1'b0, 0);
    expect_err("R3 protected write blocked", 2);
    run_txn(32'h4100_0004, 1'b1, 0);
    expect_access("R3 protected read allowed", 2, 1, 3, 0, 0);
    run_txn(32'h4000_0000, 1'b0, 0);
    expect_access("R3 write to unprotected bank", 1, 0, 0, 0, 0);

    // R4 R5 R6 R11: sweep of cycle length, relaxed, early, direction
    for (int scy = 0; scy < 16; scy++) begin
      for (int rl = 0; rl < 2; rl++) begin
        for (int el = 0; el < 2; el++) begin
          cfg_write(1, 1'b1, opt_word(32'hFF00_0000, scy, el[0], rl[0], 0));
          for (int r = 0; r < 2; r++) begin
            run_txn(32'h4012_3450, r[0], 0);
            expect_access(rl != 0 ? (el != 0 ? "R5 R6 relaxed early" : "R5 relaxed")
                                  : (el != 0 ? "R6 early" : "R4 waits"),
                          1, r[0], rl != 0 ? 2 * scy : scy, el[0], 0);
          end
        end
      end
    end

    // R7: external acknowledge
    cfg_write(1, 1'b1, opt_word(32'hFF00_0000, 8, 0, 0, 0));
    run_txn(32'h4000_0100, 1'b1, 2);
    chk("R7 ext ack cuts oe", oe_cnt, 2);
    chk("R7 ext ack cuts cs", cs_cnt[1], 2);
    chk("R7 no internal ack", ack_cnt, 0);
    chk("R7 busy released", int'(busy_end), 0);
    cfg_write(1, 1'b1, opt_word(32'hFF00_0000, 2, 0, 0, 0));
    run_txn(32'h4000_0100, 1'b0, 3);
    chk("R7 ext on last edge we", we_cnt, 3);
    chk("R7 ext on last edge no ack", ack_cnt, 0);

    // R8: read hold turnaround
    cfg_write(0, 1'b1, opt_word(32'hFFFF_8000, 1, 0, 0, 1));
    cfg_write(1, 1'b1, opt_word(32'hFF00_0000, 0, 0, 0, 0));
    run_txn(32'h8000_0000, 1'b1, 0);
    expect_access("R8 held read", 0, 1, 1, 0, 0);
    run_txn(32'h4000_0000, 1'b1, 0);
    expect_access("R8 switch after held read", 1, 1, 0, 0, 1);
    run_txn(32'h4000_0000, 1'b1, 0);
    expect_access("R8 no gap when flag consumed", 1, 1, 0, 0, 0);
    run_txn(32'h8000_0000, 1'b1, 0);
    run_txn(32'h8000_0004, 1'b0, 0);
    expect_access("R8 same bank no gap", 0, 0, 1, 0, 0);
    run_txn(32'h4000_0000, 1'b0, 0);
    expect_access("R8 after write no gap", 1, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule